// File: doc/BRIEF.md
# Streaming Sparse Cluster Finder

This block sits behind a column-parallel sensor readout. The sensor delivers one complete row of 5-bit ADC codes, one code per column, in a single clock. The block checks every 2×2 patch of adjacent columns and consecutive rows against one shared threshold, all columns at once. Each patch that passes the test marks a 7×7 neighbourhood of pixels for readout. Only the marked pixels leave the block. Each leaves as a sparse record that carries its row index, its column index and its sample value, and the records pass through an output FIFO.

The kernel anchor is the top-left pixel of the patch, which is the pixel in the older of the two rows and the lower column. The window is centred on the anchor. A row is emitted once every window that can reach it is known, which is four rows after it arrives. Row indices count the accepted rows of a frame from 0 to the last row and then wrap. After the last row of a frame, the block drains its line buffers without further input, and the next frame then starts clean. The emitter writes at most one record per clock, so rows must arrive at least one column-count of cycles apart.

Top module: `cf_sparse_cluster_finder`

## Requirements
- R1: A kernel position is a hit only when the 7-bit sum of its four samples is strictly greater than `thr_i`. A sum equal to the threshold is not a hit.
- R2: A hit anchored at (row a, column c) marks every pixel in rows a-3..a+3 and columns c-3..c+3 for output. Each record carries the pixel's sample value.
- R3: Windows that overlap are merged with a logical OR, so each marked pixel is emitted exactly once.
- R4: Windows are clipped at the array edges. Kernel positions exist only where both columns and both rows lie inside the array, and no record carries a row at or above NUM_ROWS or a column at or above NUM_COLS.
- R5: Rows are emitted in arrival order, and the records of a row are emitted in strictly ascending column order. A record that is held at the output because `rec_ready_i` is low stays stable.
- R6: When a record cannot be written because the FIFO is full, it is dropped and `overflow_o` is set. `overflow_o` stays set until reset, and the input is never stalled.
- R7: The row index starts at 0 after reset, increases by one for each accepted row, and wraps to 0 after row NUM_ROWS-1. Every frame after the first is indexed from 0 again.
- R8: After reset the block emits no records and `overflow_o` is low.
- R9: No kernel position combines the last row of one frame with row 0 of the next frame.
- R10: After the last row of a frame, the block drains its buffered rows on its own. A row offered while this drain is in progress is ignored and does not advance the row index.

Ports are listed in port-list order. Column `c` of `row_data_i` occupies bits `[c*5 +: 5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_valid_i | input | 1 | A full row is present on `row_data_i` |
| row_data_i | input | NUM_COLS*SAMPLE_W | One ADC code per column |
| thr_i | input | SAMPLE_W+2 | Global hit threshold |
| rec_ready_i | input | 1 | Downstream consumer takes the head record |
| rec_valid_o | output | 1 | FIFO holds a record |
| rec_row_o | output | clog2(NUM_ROWS) | Row index of the head record |
| rec_col_o | output | clog2(NUM_COLS) | Column index of the head record |
| rec_val_o | output | SAMPLE_W | Sample value of the head record |
| overflow_o | output | 1 | Sticky flag: a record was dropped |

## Verification
Single bright pixels are placed in the interior, in two corners and on the top edge. These placements separate the full 8×8 union of four overlapping windows from the clipped unions of 16, 25 and 20 pixels. A pair of pixels three columns apart checks the OR merge and the ascending column order across overlapping windows. A pair summing exactly to the threshold, scored against the same pair one below, separates a strict comparison from a greater-or-equal one, and a threshold of zero tests the low end. Directed runs cover the following: a bright pixel at the end of one frame facing a bright pixel at the start of the next; a row offered during the drain; and a stalled consumer, which must lose records rather than stall the input.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int unsigned KERNEL_TAPS = 4;
  localparam int unsigned SUM_GROWTH  = $clog2(KERNEL_TAPS);
endpackage

// File: rtl/cf_kernel.sv
module cf_kernel #(
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned SAMPLE_W = 5,
  parameter int unsigned SUM_W    = 7,
  parameter int unsigned HALO     = 3
) (
  input  logic                         en_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0] cur_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0] prev_i,
  input  logic [SUM_W-1:0]             thr_i,
  output logic [NUM_COLS-1:0]          spread_o
);
  localparam int H = int'(HALO);
  localparam int N = int'(NUM_COLS);

  logic [NUM_COLS-2:0] hit;

  for (genvar c = 0; c < NUM_COLS - 1; c++) begin : g_tap
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(cur_i[c*SAMPLE_W +: SAMPLE_W])
               + SUM_W'(cur_i[(c+1)*SAMPLE_W +: SAMPLE_W])
               + SUM_W'(prev_i[c*SAMPLE_W +: SAMPLE_W])
               + SUM_W'(prev_i[(c+1)*SAMPLE_W +: SAMPLE_W]);
    assign hit[c] = en_i && (sum > thr_i);
  end

  // widen each hit across +/-HALO columns, clipped to the array
  always_comb begin
    spread_o = '0;
    for (int o = 0; o < N; o++) begin
      for (int k = 0; k < N - 1; k++) begin
        if ((k + H >= o) && (o + H >= k)) spread_o[o] = spread_o[o] | hit[k];
      end
    end
  end
endmodule

// File: rtl/cf_emitter.sv
module cf_emitter #(
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned SAMPLE_W = 5,
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned COL_W    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NUM_COLS-1:0]          load_mask_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0] load_data_i,
  input  logic [ROW_W-1:0]             load_row_i,
  output logic                         idle_next_o,
  output logic                         drop_o,
  output logic                         push_o,
  output logic [ROW_W-1:0]             push_row_o,
  output logic [COL_W-1:0]             push_col_o,
  output logic [SAMPLE_W-1:0]          push_val_o
);
  logic [NUM_COLS-1:0]          pend_q, pend_rest;
  logic [NUM_COLS*SAMPLE_W-1:0] data_q;
  logic [ROW_W-1:0]             row_q;
  logic                         found;

  always_comb begin
    push_col_o = '0;
    found      = 1'b0;
    for (int i = 0; i < int'(NUM_COLS); i++) begin
      if (!found && pend_q[i]) begin
        push_col_o = COL_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign pend_rest   = pend_q & (pend_q - 1'b1);
  assign push_o      = |pend_q;
  assign push_row_o  = row_q;
  assign push_val_o  = data_q[push_col_o*SAMPLE_W +: SAMPLE_W];
  assign idle_next_o = ~|pend_rest;
  // a new row while the previous still has work: the rest is lost
  assign drop_o      = load_i && |pend_rest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      data_q <= '0;
      row_q  <= '0;
    end else if (load_i) begin
      pend_q <= load_mask_i;
      data_q <= load_data_i;
      row_q  <= load_row_i;
    end else begin
      pend_q <= pend_rest;
    end
  end
endmodule

// File: rtl/cf_fifo.sv
module cf_fifo #(
  parameter int unsigned WIDTH = 13,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr, rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr      = push_i && !full_o;
  assign rd      = pop_i && !empty_o;
  assign head_o  = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    if (wr) mem[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd) rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (wr && !rd)      cnt_q <= cnt_q + 1'b1;
      else if (rd && !wr) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cf_sparse_cluster_finder.sv
module cf_sparse_cluster_finder #(
  parameter int unsigned NUM_COLS   = 16,
  parameter int unsigned NUM_ROWS   = 12,
  parameter int unsigned SAMPLE_W   = 5,
  parameter int unsigned HALO       = 3,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          row_valid_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0]                  row_data_i,
  input  logic [SAMPLE_W+cf_pkg::SUM_GROWTH-1:0]        thr_i,
  input  logic                                          rec_ready_i,
  output logic                                          rec_valid_o,
  output logic [((NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1)-1:0] rec_row_o,
  output logic [((NUM_COLS > 1) ? $clog2(NUM_COLS) : 1)-1:0] rec_col_o,
  output logic [SAMPLE_W-1:0]                           rec_val_o,
  output logic                                          overflow_o
);
  localparam int unsigned SUM_W    = SAMPLE_W + cf_pkg::SUM_GROWTH;
  localparam int unsigned ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int unsigned COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int unsigned ROW_BITS = NUM_COLS * SAMPLE_W;
  localparam int unsigned DBUF     = HALO + 1;      // rows waiting for their last window
  localparam int unsigned MROWS    = 2 * HALO + 1;  // mask rows a hit can touch
  localparam int unsigned FL_W     = $clog2(DBUF + 1);
  localparam int unsigned REC_W    = ROW_W + COL_W + SAMPLE_W;

  logic [ROW_BITS-1:0] dbuf_q [DBUF];
  logic [ROW_W-1:0]    drow_q [DBUF];
  logic [DBUF-1:0]     dval_q;
  logic [NUM_COLS-1:0] mask_q [MROWS];
  logic [NUM_COLS-1:0] mask_d [MROWS];
  logic [ROW_W-1:0]    row_cnt_q;
  logic [FL_W-1:0]     flush_cnt_q;
  logic                overflow_q;

  logic                accept, flush_step, advance, kernel_en;
  logic [NUM_COLS-1:0] spread;
  logic                emit_load, emit_idle, emit_drop;
  logic                push_valid;
  logic [ROW_W-1:0]    push_row;
  logic [COL_W-1:0]    push_col;
  logic [SAMPLE_W-1:0] push_val;
  logic                fifo_empty, fifo_full;
  logic [REC_W-1:0]    fifo_head;

  assign accept     = row_valid_i && (flush_cnt_q == '0);
  assign flush_step = (flush_cnt_q != '0) && emit_idle;
  assign advance    = accept || flush_step;
  assign kernel_en  = accept && dval_q[0] && (row_cnt_q != '0);
  assign emit_load  = advance && dval_q[DBUF-1];

  cf_kernel #(
    .NUM_COLS(NUM_COLS), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .HALO(HALO)
  ) u_kernel (
    .en_i    (kernel_en),
    .cur_i   (row_data_i),
    .prev_i  (dbuf_q[0]),
    .thr_i   (thr_i),
    .spread_o(spread)
  );

  // every mask row moves one step older and collects the new windows
  always_comb begin
    for (int j = 0; j < int'(MROWS); j++) begin
      mask_d[j] = ((j < int'(MROWS) - 1) ? mask_q[(j + 1) % int'(MROWS)] : '0) | spread;
    end
  end

  cf_emitter #(
    .NUM_COLS(NUM_COLS), .SAMPLE_W(SAMPLE_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (emit_load),
    .load_mask_i(mask_d[0]),
    .load_data_i(dbuf_q[DBUF-1]),
    .load_row_i (drow_q[DBUF-1]),
    .idle_next_o(emit_idle),
    .drop_o     (emit_drop),
    .push_o     (push_valid),
    .push_row_o (push_row),
    .push_col_o (push_col),
    .push_val_o (push_val)
  );

  cf_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_valid),
    .push_data_i({push_row, push_col, push_val}),
    .pop_i      (rec_ready_i),
    .head_o     (fifo_head),
    .empty_o    (fifo_empty),
    .full_o     (fifo_full)
  );

  assign rec_valid_o = !fifo_empty;
  assign {rec_row_o, rec_col_o, rec_val_o} = fifo_head;
  assign overflow_o  = overflow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(DBUF); k++) begin
        dbuf_q[k] <= '0;
        drow_q[k] <= '0;
      end
      for (int j = 0; j < int'(MROWS); j++) mask_q[j] <= '0;
      dval_q      <= '0;
      row_cnt_q   <= '0;
      flush_cnt_q <= '0;
      overflow_q  <= 1'b0;
    end else begin
      if (emit_drop || (push_valid && fifo_full)) overflow_q <= 1'b1;
      if (advance) begin
        dbuf_q[0] <= accept ? row_data_i : '0;
        drow_q[0] <= row_cnt_q;
        dval_q    <= {dval_q[DBUF-2:0], accept};
        for (int k = 1; k < int'(DBUF); k++) begin
          dbuf_q[k] <= dbuf_q[k-1];
          drow_q[k] <= drow_q[k-1];
        end
        for (int j = 0; j < int'(MROWS); j++) begin
          mask_q[j] <= (flush_step && flush_cnt_q == FL_W'(1)) ? '0 : mask_d[j];
        end
      end
      if (accept) begin
        if (row_cnt_q == ROW_W'(NUM_ROWS - 1)) begin
          row_cnt_q   <= '0;
          flush_cnt_q <= FL_W'(DBUF);
        end else begin
          row_cnt_q <= row_cnt_q + 1'b1;
        end
      end else if (flush_step) begin
        flush_cnt_q <= flush_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cf_sparse_cluster_finder_chk.sv
module cf_sparse_cluster_finder_chk #(
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned NUM_ROWS = 12,
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned COL_W    = 4,
  parameter int unsigned SAMPLE_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rec_valid_o,
  input logic                rec_ready_i,
  input logic [ROW_W-1:0]    rec_row_o,
  input logic [COL_W-1:0]    rec_col_o,
  input logic [SAMPLE_W-1:0] rec_val_o,
  input logic                overflow_o,
  input logic                emit_load,
  input logic                push_valid,
  input logic [COL_W-1:0]    push_col
);
  logic             seen_q;
  logic [COL_W-1:0] last_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      last_col_q <= '0;
    end else if (emit_load) begin
      seen_q <= 1'b0;
    end else if (push_valid) begin
      seen_q     <= 1'b1;
      last_col_q <= push_col;
    end
  end

  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r4_row_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (32'(rec_row_o) < NUM_ROWS));

  a_r4_col_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (32'(rec_col_o) < NUM_COLS));

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable({rec_row_o, rec_col_o, rec_val_o})));

  a_r5_col_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid && seen_q) |-> (push_col > last_col_q));
endmodule

bind cf_sparse_cluster_finder cf_sparse_cluster_finder_chk #(
  .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i),
  .rec_row_o  (rec_row_o),
  .rec_col_o  (rec_col_o),
  .rec_val_o  (rec_val_o),
  .overflow_o (overflow_o),
  .emit_load  (emit_load),
  .push_valid (push_valid),
  .push_col   (push_col)
);

// File: tb/cf_sparse_cluster_finder_tb.sv
`timescale 1ns/1ps
module cf_sparse_cluster_finder_tb;
  localparam int C = 16;
  localparam int R = 12;
  localparam int W = 5;
  localparam int GAP = 22;
  localparam int NV = 9;

  // {thr, r0, c0, v0, r1, c1, v1, expected record count}
  localparam logic [40:0] VEC [NV] = '{
    {7'd30, 4'd5,  4'd7,  5'd31, 4'd0, 4'd0, 5'd0,  8'd64},  // R2 interior
    {7'd31, 4'd5,  4'd7,  5'd31, 4'd0, 4'd0, 5'd0,  8'd0},   // R1 sum equal
    {7'd30, 4'd0,  4'd0,  5'd31, 4'd0, 4'd0, 5'd0,  8'd16},  // R4 top-left
    {7'd30, 4'd11, 4'd15, 5'd31, 4'd0, 4'd0, 5'd0,  8'd25},  // R4 bottom-right
    {7'd0,  4'd5,  4'd7,  5'd1,  4'd0, 4'd0, 5'd0,  8'd64},  // R1 zero threshold
    {7'd30, 4'd0,  4'd15, 5'd31, 4'd0, 4'd0, 5'd0,  8'd20},  // R4 top-right
    {7'd30, 4'd5,  4'd5,  5'd31, 4'd5, 4'd8, 5'd31, 8'd88},  // R3 overlap
    {7'd30, 4'd5,  4'd7,  5'd20, 4'd5, 4'd8, 5'd11, 8'd56},  // R1 pair above
    {7'd31, 4'd5,  4'd7,  5'd20, 4'd5, 4'd8, 5'd11, 8'd0}    // R1 pair equal
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           row_valid = 1'b0;
  logic [C*W-1:0] row_data = '0;
  logic [6:0]     thr = '0;
  logic           ready = 1'b1;
  logic           rec_valid, overflow;
  logic [3:0]     rec_row, rec_col;
  logic [W-1:0]   rec_val;

  int checks = 0, fails = 0;
  logic [W-1:0] img [R][C];
  int mdl_n, act_n;
  int mdl_row [256], mdl_col [256], mdl_val [256];
  int act_row [256], act_col [256], act_val [256];

  always #2 clk = ~clk;

  cf_sparse_cluster_finder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_valid_i(row_valid), .row_data_i(row_data),
    .thr_i(thr), .rec_ready_i(ready), .rec_valid_o(rec_valid), .rec_row_o(rec_row),
    .rec_col_o(rec_col), .rec_val_o(rec_val), .overflow_o(overflow)
  );

  always @(negedge clk) begin
    if (rst_n && rec_valid && ready && act_n < 256) begin
      act_row[act_n] = int'(rec_row);
      act_col[act_n] = int'(rec_col);
      act_val[act_n] = int'(rec_val);
      act_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) img[r][c] = '0;
  endtask

  task automatic build_model(input int th);
    bit flag [R][C];
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) flag[r][c] = 1'b0;
    for (int a = 0; a < R - 1; a++)
      for (int b = 0; b < C - 1; b++)
        if (int'(img[a][b]) + int'(img[a][b+1]) + int'(img[a+1][b]) + int'(img[a+1][b+1]) > th)
          for (int r = a - 3; r <= a + 3; r++)
            for (int c = b - 3; c <= b + 3; c++)
              if (r >= 0 && r < R && c >= 0 && c < C) flag[r][c] = 1'b1;
    mdl_n = 0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (flag[r][c]) begin
          mdl_row[mdl_n] = r; mdl_col[mdl_n] = c; mdl_val[mdl_n] = int'(img[r][c]);
          mdl_n++;
        end
  endtask

  task automatic send_row(input int r);
    @(posedge clk); #1;
    row_valid = 1'b1;
    for (int c = 0; c < C; c++) row_data[c*W +: W] = img[r][c];
    @(posedge clk); #1;
    row_valid = 1'b0;
  endtask

  task automatic send_frame();
    for (int r = 0; r < R; r++) begin
      send_row(r);
      repeat (GAP) @(posedge clk);
    end
    repeat (150) @(posedge clk);
    #1;
  endtask

  task automatic compare_records(input string req, input int upto);
    int bad = 0;
    for (int i = 0; i < upto; i++)
      if (act_row[i] != mdl_row[i] || act_col[i] != mdl_col[i] || act_val[i] != mdl_val[i]) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    act_n = 0;
    repeat (3) @(posedge clk); #1;
    // R8 reset state
    check("R8 valid after reset", int'(rec_valid), 0);
    check("R8 overflow after reset", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    check("R8 no records idle", act_n, 0);

    // table walk; later frames also exercise R7 row wrap
    for (int v = 0; v < NV; v++) begin
      clear_img();
      thr = VEC[v][40:34];
      img[VEC[v][33:30]][VEC[v][29:26]] = VEC[v][25:21];
      if (VEC[v][12:8] != 0) img[VEC[v][20:17]][VEC[v][16:13]] = VEC[v][12:8];
      build_model(int'(thr));
      act_n = 0;
      send_frame();
      check($sformatf("R2 R3 R4 vec %0d count", v), act_n, int'(VEC[v][7:0]));
      check($sformatf("R5 R7 vec %0d records", v), act_n, mdl_n);
      compare_records($sformatf("R5 vec %0d content", v), (act_n < mdl_n) ? act_n : mdl_n);
    end
    check("R6 no overflow in normal use", int'(overflow), 0);

    // R9 frame boundary: bright last row then bright first row, thr above each
    clear_img(); thr = 7'd40; img[11][5] = 5'd31;
    act_n = 0;
    send_frame();
    clear_img(); img[0][5] = 5'd31;
    send_frame();
    check("R9 no cross-frame kernel", act_n, 0);

    // R10 row offered during drain is ignored
    clear_img(); thr = 7'd30; img[11][3] = 5'd31;
    build_model(30);
    act_n = 0;
    for (int r = 0; r < R; r++) begin
      send_row(r);
      if (r < R - 1) repeat (GAP) @(posedge clk);
    end
    @(posedge clk); #1;
    row_valid = 1'b1;
    for (int c = 0; c < C; c++) row_data[c*W +: W] = 5'd31;
    @(posedge clk); #1;
    row_valid = 1'b0;
    repeat (150) @(posedge clk); #1;
    check("R10 drain records", act_n, mdl_n);
    compare_records("R10 drain content", (act_n < mdl_n) ? act_n : mdl_n);
    clear_img(); img[0][0] = 5'd31;
    build_model(30);
    act_n = 0;
    send_frame();
    check("R10 R7 next frame from row 0", act_n, 16);
    compare_records("R10 R7 next frame content", (act_n < mdl_n) ? act_n : mdl_n);

    // R6 consumer stalled: drop, not stall
    clear_img(); img[5][7] = 5'd31;
    build_model(30);
    act_n = 0;
    ready = 1'b0;
    send_frame();
    check("R6 overflow raised", int'(overflow), 1);
    @(posedge clk); #1;
    ready = 1'b1;
    repeat (40) @(posedge clk); #1;
    check("R6 fifo depth kept", act_n, 16);
    compare_records("R6 oldest kept", act_n < 16 ? act_n : 16);
    act_n = 0;
    send_frame();
    check("R6 sticky overflow", int'(overflow), 1);
    check("R6 later frame complete", act_n, 64);

    // R8 reset clears
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R8 overflow cleared", int'(overflow), 0);
    check("R8 fifo empty", int'(rec_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule